// File: doc/BRIEF.md
# Bidirectional Parallel Port with Open-Drain Option

This block is an eight-pin general-purpose parallel port. Each pin has a data latch bit and a direction bit, both written over a simple register bus. In the two stand-alone operating modes (single-chip and bootstrap) the latch drives every pin whose direction bit is set, and the remaining pins act as inputs. A read of the data register returns a mix: the latch value for output pins and the live pin level for input pins.

A control bit switches every output into open-drain form, where a latch 0 pulls the pin low and a latch 1 releases it. In the two bus modes (expanded and test) the pins stop being a port. They become the data lines of an external bus, driven by a bus controller through its own data and enable signals. The latch, the direction bits and the open-drain bit then have no effect on the pads, though they still accept writes. The pin levels reach the bus controller in every mode.

Top module: `gpio_bidir_port`

## Requirements
- R1: After reset the data latch, the direction register and the control register all read 0x00, and in single-chip mode no pad output enable is set.
- R2: A write to the data register (address 0) updates the latch in every mode, including the bus modes (mode 2 expanded, mode 3 test). The value appears on the pins once the port returns to a stand-alone mode with the bit set as an output.
- R3: In mode 0 (single-chip) or mode 1 (bootstrap) with the open-drain bit clear, pin i is driven with latch bit i when direction bit i is 1. It is not driven when direction bit i is 0.
- R4: A read of address 0 returns latch bit i for each bit whose direction bit is 1, and the pad input level for each bit whose direction bit is 0.
- R5: Address 1 reads back the direction register. Address 2 reads back the control register, whose bit 0 is the open-drain enable. Address 3 reads 0x00.
- R6: In mode 0 or 1 with the open-drain bit set, an output bit with latch 0 drives its pin low, and an output bit with latch 1 leaves its pin undriven. No pad is ever enabled while its output value is 1.
- R7: In mode 2 or 3, every pad output enable equals the bus data-out-enable and every pad output value equals the bus data-out. The latch, direction and open-drain settings are ignored.
- R8: The bus data input equals the pad input levels in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode: 0 single-chip, 1 bootstrap, 2 expanded, 3 test |
| reg_addr_i | input | 2 | Register select: 0 data, 1 direction, 2 control |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| bus_dout_i | input | 8 | Bus controller data to drive on the pins |
| bus_doe_i | input | 1 | Bus controller drive enable |
| bus_din_o | output | 8 | Pin levels returned to the bus controller |
| pad_out_o | output | 8 | Pad output value per pin |
| pad_oe_o | output | 8 | Pad output enable per pin |
| pad_in_i | input | 8 | Pad input level per pin |

## Verification
A corrupted latch or direction bit shows up on the pad outputs in the cycle after the write that set it, provided the port is in a stand-alone mode. In the bus modes it stays hidden until the mode returns to single-chip or bootstrap. A wrong read-back select shows at once on the combinational read data in the same cycle. Because pins are released rather than driven when the open-drain bit is set, a faulty open-drain gate shows as a pin that a pull-up should hold high but that the pad drives instead.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BOOT   = 2'd1,
    MODE_EXPAND = 2'd2,
    MODE_TEST   = 2'd3
  } port_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Bus modes hand the pins to the external data bus.
  function automatic logic is_bus_mode(input logic [1:0] m);
    return m[1];
  endfunction

  // Read-back mix: outputs return latch, inputs return pin level.
  function automatic logic [PORT_W-1:0] mix_read(input logic [PORT_W-1:0] latch,
                                                 input logic [PORT_W-1:0] dir,
                                                 input logic [PORT_W-1:0] pins);
    return (dir & latch) | (~dir & pins);
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pins_i,
  output logic [PORT_W-1:0] rdata_o,
  output logic [PORT_W-1:0] latch_o,
  output logic [PORT_W-1:0] dir_o,
  output logic              od_en_o
);
  logic wr_data, wr_dir, wr_ctrl;

  assign wr_data = wr_i && (addr_i == SEL_DATA);
  assign wr_dir  = wr_i && (addr_i == SEL_DIR);
  assign wr_ctrl = wr_i && (addr_i == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_o <= '0;
      dir_o   <= '0;
      od_en_o <= 1'b0;
    end else begin
      if (wr_data) latch_o <= wdata_i;
      if (wr_dir)  dir_o   <= wdata_i;
      if (wr_ctrl) od_en_o <= wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr_i)
      SEL_DATA: rdata_o = mix_read(latch_o, dir_o, pins_i);
      SEL_DIR:  rdata_o = dir_o;
      SEL_CTRL: rdata_o = {{(PORT_W-1){1'b0}}, od_en_o};
      default:  rdata_o = '0;
    endcase
  end

  // R2: a data write lands in the latch on the next edge
  p_latch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (latch_o == $past(wdata_i)));
  // R5: a direction write lands on the next edge
  p_dir_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [PORT_W-1:0] latch_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic              od_en_i,
  input  logic [PORT_W-1:0] bus_dout_i,
  input  logic              bus_doe_i,
  output logic [PORT_W-1:0] pad_out_o,
  output logic [PORT_W-1:0] pad_oe_o
);
  logic bus_take;
  logic od_active;

  assign bus_take  = is_bus_mode(mode_i);
  assign od_active = od_en_i && !bus_take;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic port_out, port_oe;
    always_comb begin
      if (od_active) begin
        port_out = 1'b0;
        port_oe  = dir_i[i] && !latch_i[i];
      end else begin
        port_out = latch_i[i];
        port_oe  = dir_i[i];
      end
    end
    assign pad_out_o[i] = bus_take ? bus_dout_i[i] : port_out;
    assign pad_oe_o[i]  = bus_take ? bus_doe_i     : port_oe;
  end

  // R6: open-drain never drives a high level in stand-alone modes
  p_od_no_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (od_en_i && !mode_i[1]) |-> ((pad_oe_o & pad_out_o) == '0));
  // R3: an input-direction pin is never driven in stand-alone modes
  p_input_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i[1] |-> ((pad_oe_o & ~dir_i) == '0));
endmodule

// File: rtl/gpio_bidir_port.sv
module gpio_bidir_port
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [PORT_W-1:0] reg_wdata_i,
  output logic [PORT_W-1:0] reg_rdata_o,
  input  logic [PORT_W-1:0] bus_dout_i,
  input  logic              bus_doe_i,
  output logic [PORT_W-1:0] bus_din_o,
  output logic [PORT_W-1:0] pad_out_o,
  output logic [PORT_W-1:0] pad_oe_o,
  input  logic [PORT_W-1:0] pad_in_i
);
  logic [PORT_W-1:0] latch_q, dir_q;
  logic              od_en_q;

  gpio_port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .pins_i(pad_in_i), .rdata_o(reg_rdata_o),
    .latch_o(latch_q), .dir_o(dir_q), .od_en_o(od_en_q)
  );

  gpio_pad_ctrl u_pads (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .latch_i(latch_q),
    .dir_i(dir_q), .od_en_i(od_en_q), .bus_dout_i(bus_dout_i),
    .bus_doe_i(bus_doe_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  assign bus_din_o = pad_in_i;

  // R1: the edge leaving reset finds every pin released
  p_reset_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !mode_i[1]) |-> (pad_oe_o == '0));
  // R7: bus modes enable all pads together or none
  p_bus_uniform_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[1] |-> (pad_oe_o == '0 || pad_oe_o == '1));
endmodule

// File: tb/gpio_bidir_port_tb.sv
module gpio_bidir_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] bus_dout = 8'h00;
  logic       bus_doe = 1'b0;
  logic [7:0] bus_din, pad_out, pad_oe;
  logic [7:0] ext_en = 8'h00, ext_val = 8'h00;
  logic [7:0] pin;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  // Pad model: own drive, else external drive, else pull-up.
  assign pin = (pad_oe & pad_out) | (~pad_oe & ext_en & ext_val) | (~pad_oe & ~ext_en);

  gpio_bidir_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bus_dout_i(bus_dout),
    .bus_doe_i(bus_doe), .bus_din_o(bus_din), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_in_i(pin)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_read(2'd1, d); check("R1", "dir after reset", d, 8'h00);
    reg_read(2'd2, d); check("R1", "ctrl after reset", d, 8'h00);
    reg_read(2'd0, d); check("R1", "data read, all inputs pulled up", d, 8'hFF);
    check("R1", "pad_oe after reset", pad_oe, 8'h00);
  endtask

  task automatic t_push_pull();
    logic [7:0] d;
    mode = 2'd0;
    reg_write(2'd0, 8'h3C);
    reg_write(2'd1, 8'h0F);
    #1;
    check("R3", "single oe", pad_oe, 8'h0F);
    check("R3", "single driven pins", pin & 8'h0F, 8'h0C);
    ext_en = 8'hF0; ext_val = 8'h50;
    reg_read(2'd0, d); check("R4", "mixed read", d, 8'h5C);
    reg_read(2'd1, d); check("R5", "dir read", d, 8'h0F);
    reg_read(2'd3, d); check("R5", "unused address", d, 8'h00);
    check("R8", "bus_din in single", bus_din, 8'h5C);
    mode = 2'd1; #1;
    check("R3", "bootstrap oe", pad_oe, 8'h0F);
    ext_en = 8'h00;
  endtask

  task automatic t_open_drain();
    logic [7:0] d;
    reg_write(2'd2, 8'h01);
    reg_write(2'd1, 8'hFF);
    reg_write(2'd0, 8'h96);
    #1;
    reg_read(2'd2, d); check("R5", "ctrl read", d, 8'h01);
    check("R6", "od oe only on zeros", pad_oe, 8'h69);
    check("R6", "od never drives high", pad_oe & pad_out, 8'h00);
    check("R6", "od pins with pull-ups", pin, 8'h96);
    ext_en = 8'h02; ext_val = 8'h00;
    #1; check("R6", "released pin pulled low externally", pin, 8'h94);
    reg_read(2'd0, d); check("R4", "od read returns latch", d, 8'h96);
    ext_en = 8'h00;
  endtask

  task automatic t_bus();
    mode = 2'd2; bus_doe = 1'b1; bus_dout = 8'h5A; #1;
    check("R7", "expanded oe", pad_oe, 8'hFF);
    check("R7", "expanded out ignores od", pad_out, 8'h5A);
    bus_doe = 1'b0; ext_en = 8'hFF; ext_val = 8'hC3; #1;
    check("R7", "expanded released", pad_oe, 8'h00);
    check("R8", "bus_din from pins", bus_din, 8'hC3);
    mode = 2'd3; bus_doe = 1'b1; bus_dout = 8'h11; ext_en = 8'h00;
    reg_write(2'd0, 8'hA5);
    #1; check("R2", "test mode pads ignore latch", pad_out, 8'h11);
    reg_write(2'd2, 8'h00);
    mode = 2'd0; bus_doe = 1'b0; #1;
    check("R2", "latch written in bus mode", pad_out, 8'hA5);
    check("R2", "pins after return", pin, 8'hA5);
  endtask

  initial begin : watchdog
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_push_pull();
    t_open_drain();
    t_bus();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule